// File: doc/BRIEF.md
# Low-Transition Test Pattern Generator

This block produces test vectors for on-chip self-test of a logic block. A Galois-style feedback shift register, advanced by a parameterized number of shifts per base step, supplies the pseudorandom base patterns. A small control machine places intermediate vectors between each pair of consecutive base patterns. The vectors applied to the logic under test are therefore strongly correlated, and each step toggles fewer bits than a jump straight from one base pattern to the next.

The vector register is split into an upper half and a lower half, each with its own write enable. The control machine never raises both enables in the same cycle once a run is under way. First the lower half takes its next value while the upper half keeps its old one, which gives a half-old, half-new vector. Then the upper half catches up. An optional insertion mode adds one more vector in which the upper half is filled with a selectable constant bit before the next base pattern appears. Software or a test controller loads a seed, raises the run enable and collects one vector per strobe until the done flag rises.

Top module: `lt_bist_tpg`

## Requirements
- R1: While reset is high and in the first cycle after it, `vec_valid` and `done` are 0 and `vec` is all zeros.
- R2: After a seed load with a non-zero seed, the first emitted vector equals the seed.
- R3: A seed load with an all-zero seed is replaced by the non-zero parameter `SEED_INIT`, so the first emitted vector is `SEED_INIT`.
- R4: The base patterns follow T(j+1) = G(T(j)), where G applies `SHIFTS` Galois right shifts: each shift moves the state right by one and XORs in `TAPS` when the bit shifted out (bit 0) was 1.
- R5: With `ins_mode` low, the emitted order repeats every two vectors: T(j), then a vector whose upper N/2 bits are from T(j) and whose lower N/2 bits are from T(j+1).
- R6: With `ins_mode` high, the order repeats every three vectors: T(j), the half-old/half-new vector, then a vector whose upper N/2 bits all equal `ins_bit` and whose lower N/2 bits are from T(j+1).
- R7: Two vectors emitted in consecutive cycles differ in at most one half.
- R8: With `ins_mode` low, each step between consecutive emitted vectors toggles no more bits than the direct step between the two base patterns it lies between.
- R9: `vec_valid` is high for exactly one cycle per emitted vector, and only in the cycle after `en` was high with no seed load and no done. While `en` is low, `vec` holds its value and the sequence resumes where it stopped.
- R10: `done` rises together with the strobe of the `PAT_COUNT`-th vector emitted since reset. It then stays high until reset, a seed load does not clear it, and no further strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; one vector is emitted per cycle while high |
| seed_load | input | 1 | Load `seed` and restart at a base pattern |
| seed | input | N | Seed value; zero is replaced by `SEED_INIT` |
| ins_mode | input | 1 | Enable the constant-fill intermediate vector |
| ins_bit | input | 1 | Constant used for the fill vector |
| vec | output | N | Current test vector |
| vec_valid | output | 1 | One-cycle strobe per emitted vector |
| done | output | 1 | Pattern count reached; held until reset |

## Verification
Every phase of the control machine produces a vector that can be seen at the ports. A wrong phase, a wrong half enable or a mis-stepped feedback register therefore shows up in the very next strobed vector, as a wrong value or as both halves changing at once. A bad pattern counter shows up as `done` rising one strobe early or late. A lost hold shows up as `vec` drifting while `en` is low. The bench compares each strobed vector against a separate model of the shift register and of the phase order, and bounds the bit toggles of every step.

// File: rtl/lt_bist_pkg.sv
package lt_bist_pkg;

    typedef enum logic [1:0] {
        PH_BASE = 2'd0,
        PH_MIX  = 2'd1,
        PH_FILL = 2'd2
    } phase_e;

    typedef struct packed {
        logic   emit;
        logic   up_we;
        logic   lo_we;
        logic   adv;
        phase_e ph;
    } ctrl_t;

endpackage

// File: rtl/lt_glfsr_core.sv
module lt_glfsr_core #(
    parameter int unsigned     N         = 16,
    parameter logic [N-1:0]    TAPS      = 16'hB400,
    parameter int unsigned     SHIFTS    = 2,
    parameter logic [N-1:0]    SEED_INIT = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] seed,
    input  logic         adv,
    output logic [N-1:0] cur,
    output logic [N-1:0] nxt
);
    logic [N-1:0] state_q;

    always_comb begin
        logic [N-1:0] acc;
        acc = state_q;
        for (int i = 0; i < int'(SHIFTS); i++) begin
            acc = {1'b0, acc[N-1:1]} ^ (acc[0] ? TAPS : '0);
        end
        nxt = acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED_INIT;
        end else if (load) begin
            state_q <= (seed == '0) ? SEED_INIT : seed;
        end else if (adv) begin
            state_q <= nxt;
        end
    end

    assign cur = state_q;
endmodule

// File: rtl/lt_phase_ctrl.sv
module lt_phase_ctrl
    import lt_bist_pkg::*;
#(
    parameter int unsigned PAT_COUNT = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  load,
    input  logic  ins_mode,
    output ctrl_t ctrl,
    output logic  done
);
    localparam int unsigned CW = $clog2(PAT_COUNT + 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          first_q;
    phase_e        phase_d;
    logic          emit;

    assign emit = en && !done_q && !load;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_BASE: phase_d = PH_MIX;
            PH_MIX:  phase_d = ins_mode ? PH_FILL : PH_BASE;
            PH_FILL: phase_d = PH_BASE;
            default: phase_d = PH_BASE;
        endcase
    end

    always_comb begin
        ctrl.emit  = emit;
        ctrl.ph    = phase_q;
        ctrl.up_we = emit && (phase_q == PH_BASE || phase_q == PH_FILL);
        ctrl.lo_we = emit && (phase_q == PH_MIX || (phase_q == PH_BASE && first_q));
        ctrl.adv   = emit && ((phase_q == PH_MIX && !ins_mode) || phase_q == PH_FILL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_BASE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            first_q <= 1'b1;
        end else if (load) begin
            phase_q <= PH_BASE;
            first_q <= 1'b1;
        end else if (emit) begin
            phase_q <= phase_d;
            first_q <= 1'b0;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CW'(PAT_COUNT - 1)) begin
                done_q <= 1'b1;
            end
        end
    end

    assign done = done_q;
endmodule

// File: rtl/lt_half_lanes.sv
module lt_half_lanes
    import lt_bist_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] nxt,
    input  logic         ins_bit,
    output logic [N-1:0] vec,
    output logic         vec_valid
);
    localparam int unsigned H = N / 2;

    for (genvar h = 0; h < 2; h++) begin : g_lane
        logic [H-1:0] q;
        logic [H-1:0] d;
        logic         we;

        if (h == 1) begin : g_up
            always_comb begin
                d  = (ctrl.ph == PH_FILL) ? {H{ins_bit}} : cur[N-1:H];
                we = ctrl.up_we;
            end
        end else begin : g_lo
            always_comb begin
                d  = (ctrl.ph == PH_MIX) ? nxt[H-1:0] : cur[H-1:0];
                we = ctrl.lo_we;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we) begin
                q <= d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= ctrl.emit;
        end
    end

    assign vec = {g_lane[1].q, g_lane[0].q};
endmodule

// File: rtl/lt_bist_tpg.sv
module lt_bist_tpg
    import lt_bist_pkg::*;
#(
    parameter int unsigned  N         = 16,
    parameter logic [N-1:0] TAPS      = 16'hB400,
    parameter int unsigned  SHIFTS    = 2,
    parameter logic [N-1:0] SEED_INIT = 16'hACE1,
    parameter int unsigned  PAT_COUNT = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         seed_load,
    input  logic [N-1:0] seed,
    input  logic         ins_mode,
    input  logic         ins_bit,
    output logic [N-1:0] vec,
    output logic         vec_valid,
    output logic         done
);
    ctrl_t        ctrl;
    logic [N-1:0] cur;
    logic [N-1:0] nxt;

    lt_glfsr_core #(
        .N(N), .TAPS(TAPS), .SHIFTS(SHIFTS), .SEED_INIT(SEED_INIT)
    ) i_core (
        .clk(clk), .rst(rst), .load(seed_load), .seed(seed),
        .adv(ctrl.adv), .cur(cur), .nxt(nxt)
    );

    lt_phase_ctrl #(
        .PAT_COUNT(PAT_COUNT)
    ) i_ctrl (
        .clk(clk), .rst(rst), .en(en), .load(seed_load),
        .ins_mode(ins_mode), .ctrl(ctrl), .done(done)
    );

    lt_half_lanes #(
        .N(N)
    ) i_lanes (
        .clk(clk), .rst(rst), .ctrl(ctrl), .cur(cur), .nxt(nxt),
        .ins_bit(ins_bit), .vec(vec), .vec_valid(vec_valid)
    );
endmodule

// File: rtl/lt_bist_tpg_chk.sv
module lt_bist_tpg_chk #(
    parameter int unsigned N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         seed_load,
    input logic [N-1:0] vec,
    input logic         vec_valid,
    input logic         done
);
    localparam int unsigned H = N / 2;

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!vec_valid && !done && vec == '0));

    p_one_half_r7: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && $past(vec_valid)) |->
            (vec[N-1:H] == $past(vec[N-1:H]) || vec[H-1:0] == $past(vec[H-1:0])));

    p_valid_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> ($past(en) && !$past(seed_load)));

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> $stable(vec));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_no_strobe_after_done_r10: assert property (@(posedge clk) disable iff (rst)
        $past(done) |-> !vec_valid);
endmodule

bind lt_bist_tpg lt_bist_tpg_chk #(.N(N)) i_chk (
    .clk(clk), .rst(rst), .en(en), .seed_load(seed_load),
    .vec(vec), .vec_valid(vec_valid), .done(done)
);

// File: tb/test_lt_bist_tpg.sv
module test_lt_bist_tpg;
    localparam int unsigned N      = 16;
    localparam int unsigned H      = N / 2;
    localparam logic [N-1:0] TAPS  = 16'hB400;
    localparam int unsigned SHIFTS = 2;
    localparam logic [N-1:0] SINIT = 16'hACE1;
    localparam int unsigned PCOUNT = 40;

    typedef struct packed {
        logic [15:0] seed;
        logic        ins;
        logic        ib;
        logic [7:0]  nvec;
    } case_t;

    localparam case_t CASES [5] = '{
        '{seed: 16'h0001, ins: 1'b0, ib: 1'b0, nvec: 8'd20},
        '{seed: 16'hFFFF, ins: 1'b0, ib: 1'b0, nvec: 8'd18},
        '{seed: 16'h1234, ins: 1'b1, ib: 1'b1, nvec: 8'd21},
        '{seed: 16'h8000, ins: 1'b1, ib: 1'b0, nvec: 8'd24},
        '{seed: 16'h5A5A, ins: 1'b0, ib: 1'b1, nvec: 8'd16}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         seed_load = 1'b0;
    logic [N-1:0] seed = '0;
    logic         ins_mode = 1'b0;
    logic         ins_bit = 1'b0;
    logic [N-1:0] vec;
    logic         vec_valid;
    logic         done;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    lt_bist_tpg #(
        .N(N), .TAPS(TAPS), .SHIFTS(SHIFTS), .SEED_INIT(SINIT), .PAT_COUNT(PCOUNT)
    ) i_lt_bist_tpg (
        .clk(clk), .rst(rst), .en(en), .seed_load(seed_load), .seed(seed),
        .ins_mode(ins_mode), .ins_bit(ins_bit),
        .vec(vec), .vec_valid(vec_valid), .done(done)
    );

    function automatic logic [N-1:0] g_step(logic [N-1:0] s);
        logic [N-1:0] r;
        r = s;
        for (int i = 0; i < int'(SHIFTS); i++) begin
            if (r[0]) r = (r >> 1) ^ TAPS;
            else      r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [N-1:0] base_t(logic [N-1:0] s, int j);
        logic [N-1:0] t;
        t = s;
        for (int i = 0; i < j; i++) t = g_step(t);
        return t;
    endfunction

    function automatic logic [N-1:0] exp_vec(logic [N-1:0] s, logic ins, logic ib, int k);
        int per;
        logic [N-1:0] t;
        logic [N-1:0] nx;
        per = ins ? 3 : 2;
        t  = base_t(s, k / per);
        nx = g_step(t);
        case (k % per)
            0: return t;
            1: return {t[N-1:H], nx[H-1:0]};
            default: return {{H{ib}}, nx[H-1:0]};
        endcase
    endfunction

    function automatic int popc(logic [N-1:0] v);
        int c;
        c = 0;
        for (int i = 0; i < int'(N); i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; seed_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_seed(logic [N-1:0] s);
        @(negedge clk);
        seed = s; seed_load = 1'b1; en = 1'b0;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    task automatic run_case(logic [N-1:0] s, logic ins, logic ib, int nvec, string tag);
        logic [N-1:0] eff;
        logic [N-1:0] prev;
        eff = (s == '0) ? SINIT : s;
        ins_mode = ins; ins_bit = ib;
        load_seed(s);
        en = 1'b1;
        prev = '0;
        for (int k = 0; k < nvec; k++) begin
            @(negedge clk);
            check({tag, " strobe R9"}, N'(vec_valid), N'(1));
            check({tag, (ins ? " order R6" : " order R5")}, vec, exp_vec(eff, ins, ib, k));
            if (k == 0) check({tag, " first R2"}, vec, eff);
            if (k > 0) begin
                logic [N-1:0] d;
                d = vec ^ prev;
                check({tag, " one half R7"},
                      N'((d[N-1:H] == '0) || (d[H-1:0] == '0)), N'(1));
                if (!ins) begin
                    int p;
                    p = (k - 1) / 2;
                    check({tag, " toggles R8"},
                          N'(popc(d) <= popc(base_t(eff, p) ^ base_t(eff, p + 1))), N'(1));
                end
            end
            prev = vec;
        end
        en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [N-1:0] held;
        @(negedge clk);
        check("reset vec R1", vec, '0);
        check("reset valid R1", N'(vec_valid), '0);
        check("reset done R1", N'(done), '0);
        rst = 1'b0;
        @(negedge clk);
        check("post-reset vec R1", vec, '0);

        // Base-sequence walk R4 (base positions), order R5/R6, toggles R8
        for (int c = 0; c < 5; c++) begin
            do_reset();
            run_case(CASES[c].seed, CASES[c].ins, CASES[c].ib, int'(CASES[c].nvec), "table");
        end

        // Base patterns directly against the shift model, R4
        do_reset();
        ins_mode = 1'b0;
        load_seed(16'h0F0F);
        en = 1'b1;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            check("base R4", vec, base_t(16'h0F0F, j));
            @(negedge clk);
        end
        en = 1'b0;

        // Zero seed replaced, R3
        do_reset();
        run_case('0, 1'b0, 1'b0, 4, "zero seed R3");

        // Hold while en low, then resume, R9
        do_reset();
        ins_mode = 1'b1; ins_bit = 1'b1;
        load_seed(16'hC3A5);
        en = 1'b1;
        repeat (4) @(negedge clk);
        check("pre-hold R9", vec, exp_vec(16'hC3A5, 1'b1, 1'b1, 3));
        held = vec;
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("hold valid R9", N'(vec_valid), '0);
            check("hold vec R9", vec, held);
        end
        en = 1'b1;
        @(negedge clk);
        check("resume R9", vec, exp_vec(16'hC3A5, 1'b1, 1'b1, 4));
        en = 1'b0;

        // Done after PCOUNT strobes, R10
        do_reset();
        ins_mode = 1'b0;
        load_seed(16'h7777);
        en = 1'b1;
        for (int k = 1; k <= int'(PCOUNT); k++) begin
            @(negedge clk);
            if (k == int'(PCOUNT) - 1) check("done early R10", N'(done), '0);
        end
        check("done rises R10", N'(done), N'(1));
        check("last strobe R10", N'(vec_valid), N'(1));
        @(negedge clk);
        check("no strobe after done R10", N'(vec_valid), '0);
        en = 1'b0;
        load_seed(16'h1111);
        en = 1'b1;
        repeat (2) @(negedge clk);
        check("done kept over load R10", N'(done), N'(1));
        check("still no strobe R10", N'(vec_valid), '0);
        en = 1'b0;
        do_reset();
        @(negedge clk);
        check("done cleared by reset R1", N'(done), '0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule